// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Signed Compare

This block is a purely combinational integer arithmetic logic unit for a datapath. Two operands and a three-bit operation code go in. The same cycle it returns a result word, a zero flag, a signed-overflow flag and the carry out of the top bit. It performs bitwise AND, bitwise OR, addition, subtraction and a signed "set if less than" compare. The compare gives the value 1 or 0 in the result word.

The unit is a chain of identical one-bit cells with a separate cell for the top bit. Carries pass from each cell to the next higher one. The top bit of the operation code is one negate line: it inverts the second operand in every cell and also forms the carry into bit 0, so subtraction is a + ~b + 1. For the compare, the top cell turns its adder output into a corrected sign. That sign is sent back to the result selector of bit 0, and every other bit selects a constant 0.

The word width is a parameter; the default is 32.

Top module: `ripple_alu`

## Requirements
- R1: Code 3'b000 gives result = opnd_a AND opnd_b, bit by bit.
- R2: Code 3'b001 gives result = opnd_a OR opnd_b, bit by bit.
- R3: Code 3'b010 gives result = (opnd_a + opnd_b) modulo 2^WIDTH, and carry_out is the bit carried out of the top position of that sum.
- R4: Code 3'b110 gives result = (opnd_a - opnd_b) modulo 2^WIDTH, and carry_out = 1 exactly when opnd_a >= opnd_b taken as unsigned values (no borrow).
- R5: Code 3'b111 gives result = 1 when opnd_a < opnd_b taken as two's-complement signed values, and 0 otherwise. Bits WIDTH-1 down to 1 of the result are always 0. The answer stays correct when a - b overflows.
- R6: zero_flag is 1 exactly when every result bit is 0, for every operation code.
- R7: For code 3'b010, ovf_flag is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it. For codes 3'b110 and 3'b111, ovf_flag is 1 exactly when the operands' sign bits differ and the sign bit of the difference differs from that of opnd_a.
- R8: The carry into bit 0 equals code bit 2. So 0 - 1 gives all ones with carry_out 0, and all-ones + 1 gives 0 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (bit 2 is the negate line, bits 1:0 choose the cell output) |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Result word |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Two's-complement overflow of the add or subtract |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench targets compares whose difference overflows, such as the most negative value against a positive one. A unit that sends back the raw sign of the difference gives the wrong answer there. Full-length carry ripples are tested: all ones plus one, and zero minus one. A broken link in the chain, or a carry-in not tied to the negate line, shows up as a wrong top result bit or a wrong carry_out. Overflow is tested with both sign pairings in add and in subtract, because a detector that ignores the inverted operand reports subtraction overflow on the wrong pairs. Equal operands under subtract are tested, because they must raise zero_flag and carry_out together.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } cell_pick_e;

    typedef struct packed {
        logic res;
        logic sum;
        logic cout;
    } cell_out_t;

endpackage

// File: rtl/ralu_slice.sv
module ralu_slice
    import ralu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       neg_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  logic [1:0] pick_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    cell_out_t cell_d;
    logic      b_eff;

    always_comb begin
        b_eff       = b_i ^ neg_i;
        cell_d.sum  = a_i ^ b_eff ^ cin_i;
        cell_d.cout = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
        case (cell_pick_e'(pick_i))
            PICK_AND:  cell_d.res = a_i & b_i;
            PICK_OR:   cell_d.res = a_i | b_i;
            PICK_SUM:  cell_d.res = cell_d.sum;
            default:   cell_d.res = less_i;
        endcase
    end

    assign res_o  = cell_d.res;
    assign sum_o  = cell_d.sum;
    assign cout_o = cell_d.cout;

endmodule

// File: rtl/ralu_msb_slice.sv
module ralu_msb_slice
    import ralu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       neg_i,
    input  logic       cin_i,
    input  logic [1:0] pick_i,
    output logic       res_o,
    output logic       cout_o,
    output logic       ovf_o,
    output logic       set_o
);

    logic sum_w;
    logic b_eff;

    ralu_slice u_cell (
        .a_i    (a_i),
        .b_i    (b_i),
        .neg_i  (neg_i),
        .cin_i  (cin_i),
        .less_i (1'b0),
        .pick_i (pick_i),
        .res_o  (res_o),
        .sum_o  (sum_w),
        .cout_o (cout_o)
    );

    always_comb begin
        b_eff = b_i ^ neg_i;
        ovf_o = (a_i == b_eff) && (sum_w != a_i);
        set_o = sum_w ^ ovf_o;
    end

endmodule

// File: rtl/ralu_zero_det.sv
module ralu_zero_det #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             zero_o
);

    assign zero_o = ~(|vec_i);

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ralu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    logic             neg_w;
    logic [1:0]       pick_w;
    logic             carry [WIDTH+1];
    logic [MSB:0]     res_w;
    logic [MSB-1:0]   sum_unused;
    logic             less_fb;
    logic             ovf_w;

    assign neg_w    = op_sel[2];
    assign pick_w   = op_sel[1:0];
    assign carry[0] = neg_w;

    for (genvar i = 0; i < MSB; i++) begin : g_cell
        logic less_w;
        if (i == 0) begin : g_low
            assign less_w = less_fb;
        end else begin : g_hi
            assign less_w = 1'b0;
        end
        ralu_slice u_cell (
            .a_i    (opnd_a[i]),
            .b_i    (opnd_b[i]),
            .neg_i  (neg_w),
            .cin_i  (carry[i]),
            .less_i (less_w),
            .pick_i (pick_w),
            .res_o  (res_w[i]),
            .sum_o  (sum_unused[i]),
            .cout_o (carry[i+1])
        );
    end

    ralu_msb_slice u_top (
        .a_i    (opnd_a[MSB]),
        .b_i    (opnd_b[MSB]),
        .neg_i  (neg_w),
        .cin_i  (carry[MSB]),
        .pick_i (pick_w),
        .res_o  (res_w[MSB]),
        .cout_o (carry[WIDTH]),
        .ovf_o  (ovf_w),
        .set_o  (less_fb)
    );

    ralu_zero_det #(.WIDTH(WIDTH)) u_zero (
        .vec_i  (res_w),
        .zero_o (zero_flag)
    );

    assign result    = res_w;
    assign ovf_flag  = ovf_w;
    assign carry_out = carry[WIDTH];

    always_comb begin
        // R6
        zero_flag_chk: assert (zero_flag == (result == '0))
            else $error("zero flag disagrees with result");
        if (op_sel == OP_AND) begin
            // R1
            and_res_chk: assert (result == (opnd_a & opnd_b))
                else $error("AND result wrong");
        end
        if (op_sel == OP_OR) begin
            // R2
            or_res_chk: assert (result == (opnd_a | opnd_b))
                else $error("OR result wrong");
        end
        if (op_sel == OP_SLT) begin
            // R5
            slt_upper_chk: assert (result[MSB:1] == '0)
                else $error("compare result has upper bits set");
        end
        if (op_sel == OP_ADD && opnd_a[MSB] != opnd_b[MSB]) begin
            // R7
            no_overflow_chk: assert (!ovf_flag)
                else $error("overflow on mixed-sign add");
        end
        if (op_sel == OP_SUB && opnd_a == opnd_b) begin
            // R4
            sub_equal_chk: assert (zero_flag && carry_out && !ovf_flag)
                else $error("equal subtract flags wrong");
        end
    end

endmodule

// File: tb/sim_ripple_alu.sv
`timescale 1ns/1ps
module sim_ripple_alu;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         zero_flag;
    logic         ovf_flag;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_abcd;

    always #10 clk = ~clk;

    ripple_alu #(.WIDTH(W)) u0 (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        longint ua, ub, exp_r, exp_c;
        bit     exp_v, sa, sb, sr;
        string  rq;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
        ua = longint'(a); ub = longint'(b);
        exp_c = 0; exp_v = 0;
        sa = a[W-1]; sb = b[W-1];
        case (op)
            3'b000: begin rq = "R1"; exp_r = ua & ub; end
            3'b001: begin rq = "R2"; exp_r = ua | ub; end
            3'b010: begin
                rq = "R3";
                exp_r = (ua + ub) & 64'hFFFF_FFFF;
                exp_c = (ua + ub) >> W;
                sr = exp_r[W-1];
                exp_v = (sa == sb) && (sr != sa);
            end
            3'b110: begin
                rq = "R4";
                exp_r = (ua - ub) & 64'hFFFF_FFFF;
                exp_c = (ua >= ub) ? 1 : 0;
                sr = exp_r[W-1];
                exp_v = (sa != sb) && (sr != sa);
            end
            default: begin
                rq = "R5";
                exp_r = ($signed(a) < $signed(b)) ? 1 : 0;
                sr = a[W-1] ^ b[W-1] ^ 1'b0;
                sr = ((ua - ub) >> (W-1)) & 1;
                exp_v = (sa != sb) && (sr != sa);
            end
        endcase
        check(rq, "result", longint'(result), exp_r);
        check("R6", "zero_flag", longint'(zero_flag), (exp_r == 0) ? 1 : 0);
        if (op == 3'b010 || op == 3'b110 || op == 3'b111)
            check("R7", "ovf_flag", longint'(ovf_flag), longint'(exp_v));
        if (op == 3'b010 || op == 3'b110)
            check("R8", "carry_out", longint'(carry_out), exp_c);
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        logic [2:0] ops [5];
        ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010;
        ops[3] = 3'b110; ops[4] = 3'b111;

        // idle state: all-zero operands under AND give zero result, zero flag (R6)
        @(posedge clk); #1;
        check("R6", "idle result", longint'(result), 0);
        check("R6", "idle zero_flag", longint'(zero_flag), 1);

        // R1 / R2 patterns
        apply(3'b000, 32'hF0F0_F0F0, 32'hFF00_FF00);
        apply(3'b001, 32'h0F0F_0000, 32'h0000_F0F0);
        apply(3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
        // R3 / R8 full ripple
        apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(3'b010, 32'h0000_0002, 32'h0000_0003);
        // R7 add overflow, both sign pairings
        apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
        apply(3'b010, 32'h8000_0000, 32'h8000_0000);
        apply(3'b010, 32'h7FFF_FFFF, 32'h8000_0000);
        // R4 / R8 borrow through every bit
        apply(3'b110, 32'h0000_0000, 32'h0000_0001);
        apply(3'b110, 32'h1234_5678, 32'h1234_5678);
        apply(3'b110, 32'h8000_0000, 32'h0000_0001);
        apply(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // R5 compares including overflowing differences
        apply(3'b111, 32'h8000_0000, 32'h0000_0001);
        apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
        apply(3'b111, 32'h0000_0005, 32'h0000_0005);
        apply(3'b111, 32'h0000_0003, 32'h0000_0009);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            seed = next_rand(seed); ra = seed;
            seed = next_rand(seed); rb = seed;
            if (n % 7 == 0) rb = ra;
            if (n % 11 == 0) ra = {~rb[31], rb[30:0]};
            apply(ops[n % 5], ra, rb);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule